// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept, looking only at its 48-bit destination address. The address is streamed in one byte per valid cycle, first byte marked by a start flag. One cycle after the sixth byte is taken, the block pulses a decision output. The pulse carries accept or reject, a code for the filter that caused the decision, and the index of the matching exact slot.

A host programs the filter through a simple write port. There is a bank of exact-match address slots with individual arm bits. A configurable number of the leading slots is set aside for unicast addresses; the remaining slots only match group addresses. There is also a 64-entry multicast hash table indexed by a 6-bit XOR fold of the address, and a mode word. The mode word holds promiscuous, all-multicast, hash-enable and broadcast-reject controls plus the unicast slot count.

Host writes go to a shadow copy. That copy is transferred to the working copy only while no address is being received, so every decision sees one consistent filter set.

Top module: `rx_da_filter`

## Requirements
- R1: Address byte n (n = 0..5, byte 0 flagged by `da_sof`, later bytes on any later cycles with `da_vld` high) forms address bits [8n+7:8n]. `dec_valid` is high for exactly one cycle, the cycle after byte 5 is taken. A new `da_sof` abandons a partly received address. `dec_accept`, `dec_kind` and `dec_slot` are 0 whenever `dec_valid` is low.
- R2: An armed slot whose 48-bit value equals the address, and whose class fits the address, gives accept with `dec_kind` = 1 (exact). `dec_slot` is the lowest such slot index. Slot k's low word (config address 2k) holds address bits [31:0]; its high word (2k+1) holds bits [47:32] in data bits [15:0].
- R3: Writing a slot's high word arms it, and writing its low word disarms it. A disarmed slot never matches.
- R4: Slots with index below the unicast count (mode bits [7:4]) match only addresses whose group bit (address bit 0) is 0. The other slots match only addresses whose group bit is 1.
- R5: The hash index h is formed by XORing address bit j into index bit (j mod 6), for j = 0..47. Table word at config address 16 holds entries 0..31 and the word at 17 holds entries 32..63 (bit h-32). A non-broadcast group address whose entry is 1 gives accept with `dec_kind` = 2 (hash), but only if hash-enable (mode bit 2) is set. Unicast addresses never use the table.
- R6: All-multicast (mode bit 1) accepts every non-broadcast group address as a hash hit, whatever the table or hash-enable hold.
- R7: When both an exact slot and the hash table match, the exact result is reported.
- R8: The all-ones address is accepted with `dec_kind` = 4 (broadcast), unless broadcast-reject (mode bit 3) is set; in that case it is rejected, whatever slots or hash table hold.
- R9: Promiscuous mode (mode bit 0) accepts every address. `dec_kind` = 3 is reported when no other rule accepts.
- R10: A config write made while an address is being received does not affect that address's decision. The write applies to addresses whose first byte arrives after at least one cycle without reception.
- R11: After reset all slots are disarmed and the table and mode are zero, so every address is rejected (`dec_kind` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 5 | Config word address (slots 0..15, hash 16..17, mode 18) |
| cfg_wdata | input | 32 | Config write data |
| da_vld | input | 1 | Address byte valid |
| da_sof | input | 1 | First byte of an address |
| da_byte | input | 8 | Address byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 3 | 0 none, 1 exact, 2 hash, 3 promiscuous, 4 broadcast |
| dec_slot | output | 3 | Index of matching exact slot |

## Verification
The hardest situation to reach is a config write that lands in the middle of an address. The bench makes it by holding `da_vld` low for a gap after the third byte and issuing the mode write during that gap. It then checks that the decision still uses the old mode and that the next address uses the new one. Hitting both halves of the hash table needs addresses with known fold values. The bench computes the fold itself, scans candidate group addresses for one index below 32 and one above, and programs only those table bits.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  parameter int DA_BYTES     = 6;
  parameter int DA_BITS      = 8 * DA_BYTES;
  parameter int HASH_BITS    = 6;
  parameter int HASH_ENTRIES = 1 << HASH_BITS;
  parameter int WORD_BITS    = 32;

  typedef enum logic [2:0] {
    DEC_NONE    = 3'd0,
    DEC_EXACT   = 3'd1,
    DEC_HASH    = 3'd2,
    DEC_PROMISC = 3'd3,
    DEC_BCAST   = 3'd4
  } dec_kind_e;

  typedef struct packed {
    logic [3:0] ucast_cnt;
    logic       bcast_dis;
    logic       hash_en;
    logic       allmulti;
    logic       promisc;
  } mode_t;
endpackage

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold
  import rxf_pkg::*;
(
  input  logic [7:0]           byte_in,
  input  logic [2:0]           offset,
  output logic [HASH_BITS-1:0] contrib
);
  logic [2:0] pos;

  always_comb begin
    contrib = '0;
    pos     = '0;
    for (int b = 0; b < 8; b++) begin
      pos = 3'((int'(offset) + b) % HASH_BITS);
      contrib[pos] = contrib[pos] ^ byte_in[b];
    end
  end
endmodule

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int CFG_AW  = 5
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [CFG_AW-1:0]                 addr,
  input  logic [WORD_BITS-1:0]              wdata,
  input  logic                              commit,
  output logic [N_SLOTS-1:0][DA_BITS-1:0]   act_addr,
  output logic [N_SLOTS-1:0]                act_en,
  output logic [HASH_ENTRIES-1:0]           act_hash,
  output mode_t                             act_mode
);
  localparam int HI_BITS   = DA_BITS - WORD_BITS;
  localparam int HASH_LO_A = 2 * N_SLOTS;
  localparam int HASH_HI_A = 2 * N_SLOTS + 1;
  localparam int MODE_A    = 2 * N_SLOTS + 2;

  logic [N_SLOTS-1:0][DA_BITS-1:0] sh_addr, sh_addr_d;
  logic [N_SLOTS-1:0]              sh_en, sh_en_d;
  logic [HASH_ENTRIES-1:0]         sh_hash, sh_hash_d;
  mode_t                           sh_mode, sh_mode_d;

  always_comb begin
    sh_addr_d = sh_addr;
    sh_en_d   = sh_en;
    sh_hash_d = sh_hash;
    sh_mode_d = sh_mode;
    if (we) begin
      for (int k = 0; k < N_SLOTS; k++) begin
        if (addr == CFG_AW'(2 * k)) begin
          sh_addr_d[k][WORD_BITS-1:0] = wdata;
          sh_en_d[k] = 1'b0;
        end
        if (addr == CFG_AW'(2 * k + 1)) begin
          sh_addr_d[k][DA_BITS-1:WORD_BITS] = wdata[HI_BITS-1:0];
          sh_en_d[k] = 1'b1;
        end
      end
      if (addr == CFG_AW'(HASH_LO_A)) sh_hash_d[WORD_BITS-1:0] = wdata;
      if (addr == CFG_AW'(HASH_HI_A)) sh_hash_d[HASH_ENTRIES-1:WORD_BITS] = wdata;
      if (addr == CFG_AW'(MODE_A))    sh_mode_d = mode_t'(wdata[$bits(mode_t)-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_addr <= '0;
      sh_en   <= '0;
      sh_hash <= '0;
      sh_mode <= '0;
    end else begin
      sh_addr <= sh_addr_d;
      sh_en   <= sh_en_d;
      sh_hash <= sh_hash_d;
      sh_mode <= sh_mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_addr <= '0;
      act_en   <= '0;
      act_hash <= '0;
      act_mode <= '0;
    end else if (commit) begin
      act_addr <= sh_addr;
      act_en   <= sh_en;
      act_hash <= sh_hash;
      act_mode <= sh_mode;
    end
  end

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_arm_chk
    a_r3_low_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == CFG_AW'(2 * k)) |=> !sh_en[k]);
    a_r3_high_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == CFG_AW'(2 * k + 1)) |=> sh_en[k]);
  end

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_addr) && $stable(act_en) && $stable(act_hash) && $stable(act_mode)));
endmodule

// File: rtl/rxf_slot_cmp.sv
module rxf_slot_cmp
  import rxf_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = 3
)(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DA_BITS-1:0]              da,
  input  logic [N_SLOTS-1:0][DA_BITS-1:0] slot_addr,
  input  logic [N_SLOTS-1:0]              slot_en,
  input  logic [3:0]                      ucast_cnt,
  output logic                            hit,
  output logic [SLOT_W-1:0]               hit_idx
);
  logic [N_SLOTS-1:0] match;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    logic class_ok;
    assign class_ok = (k < int'(ucast_cnt)) ? !da[0] : da[0];
    assign match[k] = slot_en[k] && class_ok && (slot_addr[k] == da);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = N_SLOTS - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit     = 1'b1;
        hit_idx = SLOT_W'(k);
      end
    end
  end

  a_r4_slot_class: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((int'(hit_idx) < int'(ucast_cnt)) ? !da[0] : da[0]));
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rxf_pkg::*;
#(
  parameter  int N_SLOTS = 8,
  localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CFG_AW  = $clog2(2 * N_SLOTS + 3)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [WORD_BITS-1:0] cfg_wdata,
  input  logic                 da_vld,
  input  logic                 da_sof,
  input  logic [7:0]           da_byte,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic [2:0]           dec_kind,
  output logic [SLOT_W-1:0]    dec_slot
);
  localparam int CNT_W  = $clog2(DA_BYTES);
  localparam int HOLD_W = 8 * (DA_BYTES - 1);

  logic [N_SLOTS-1:0][DA_BITS-1:0] act_addr;
  logic [N_SLOTS-1:0]              act_en;
  logic [HASH_ENTRIES-1:0]         act_hash;
  mode_t                           act_mode;

  logic [CNT_W-1:0]     cnt_q, cnt_d, idx;
  logic                 busy_q, busy_d;
  logic [HOLD_W-1:0]    hold_q, hold_d;
  logic [HASH_BITS-1:0] hash_q, hash_d, hash_now, contrib;
  logic [2:0]           offset;
  logic                 start, take, last, commit;
  logic [DA_BITS-1:0]   da_full;
  logic                 ex_hit;
  logic [SLOT_W-1:0]    ex_idx;
  logic                 is_bc, hash_hit;
  dec_kind_e            kind_d;

  logic                 dv_q, acc_q;
  dec_kind_e            kind_q;
  logic [SLOT_W-1:0]    slot_q;

  rxf_cfg_regs #(.N_SLOTS(N_SLOTS), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .commit(commit), .act_addr(act_addr), .act_en(act_en),
    .act_hash(act_hash), .act_mode(act_mode)
  );

  rxf_hash_fold u_fold (.byte_in(da_byte), .offset(offset), .contrib(contrib));

  rxf_slot_cmp #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .da(da_full), .slot_addr(act_addr),
    .slot_en(act_en), .ucast_cnt(act_mode.ucast_cnt),
    .hit(ex_hit), .hit_idx(ex_idx)
  );

  // byte sequencing and running hash
  always_comb begin
    start    = da_vld && da_sof;
    take     = da_vld && (da_sof || busy_q);
    idx      = start ? '0 : cnt_q;
    last     = take && (idx == CNT_W'(DA_BYTES - 1));
    commit   = !busy_q && !start;
    offset   = 3'((int'(idx) * 8) % HASH_BITS);
    hash_now = (start ? '0 : hash_q) ^ contrib;
    da_full  = {da_byte, hold_q};

    cnt_d  = cnt_q;
    busy_d = busy_q;
    hold_d = hold_q;
    hash_d = hash_q;
    if (take) begin
      if (last) begin
        cnt_d  = '0;
        busy_d = 1'b0;
      end else begin
        cnt_d  = idx + 1'b1;
        busy_d = 1'b1;
        hold_d[int'(idx) * 8 +: 8] = da_byte;
        hash_d = hash_now;
      end
    end
  end

  // decision rules
  always_comb begin
    is_bc    = &da_full;
    hash_hit = da_full[0] && !is_bc &&
               (act_mode.allmulti || (act_mode.hash_en && act_hash[hash_now]));
    if (is_bc) begin
      if (!act_mode.bcast_dis) kind_d = DEC_BCAST;
      else if (act_mode.promisc) kind_d = DEC_PROMISC;
      else kind_d = DEC_NONE;
    end else if (ex_hit) begin
      kind_d = DEC_EXACT;
    end else if (hash_hit) begin
      kind_d = DEC_HASH;
    end else if (act_mode.promisc) begin
      kind_d = DEC_PROMISC;
    end else begin
      kind_d = DEC_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      hold_q <= '0;
      hash_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      hold_q <= hold_d;
      hash_q <= hash_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= 1'b0;
      acc_q  <= 1'b0;
      kind_q <= DEC_NONE;
      slot_q <= '0;
    end else begin
      dv_q   <= last;
      acc_q  <= last && (kind_d != DEC_NONE);
      kind_q <= last ? kind_d : DEC_NONE;
      slot_q <= (last && kind_d == DEC_EXACT) ? ex_idx : '0;
    end
  end

  assign dec_valid  = dv_q;
  assign dec_accept = acc_q;
  assign dec_kind   = kind_q;
  assign dec_slot   = slot_q;

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  a_r1_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_kind == 3'd0 && dec_slot == '0));
  a_r9_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (last && act_mode.promisc) |=> (dec_valid && dec_accept));
  a_r8_bcast_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (last && is_bc && act_mode.bcast_dis && !act_mode.promisc) |=> !dec_accept);
endmodule

// File: tb/rx_da_filter_test.sv
module rx_da_filter_test;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        da_vld, da_sof;
  logic [7:0]  da_byte;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_kind, dec_slot;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  localparam int K_NONE = 0, K_EXACT = 1, K_HASH = 2, K_PROM = 3, K_BC = 4;
  localparam logic [4:0] A_HLO = 5'd16, A_HHI = 5'd17, A_MODE = 5'd18;

  rx_da_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_vld(da_vld), .da_sof(da_sof), .da_byte(da_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_kind(dec_kind),
    .dec_slot(dec_slot)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic [47:0] mk(input [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic [5:0] fold(input [47:0] a);
    logic [5:0] h = 0;
    int i = 0;
    for (int oc = 0; oc < 6; oc++)
      for (int bt = 0; bt < 8; bt++) begin
        h[i] = h[i] ^ a[oc * 8 + bt];
        i++;
        if (i == 6) i = 0;
      end
    return h;
  endfunction

  function automatic [31:0] mode(input bit prom, am, hen, bdis, input [3:0] uc);
    return {24'd0, uc, bdis, hen, am, prom};
  endfunction

  task automatic chk(input string tag, input [63:0] got, input [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cfg_wr(input [4:0] a, input [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_slot(input int k, input [47:0] a);
    cfg_wr(5'(2 * k), a[31:0]);
    cfg_wr(5'(2 * k + 1), {16'd0, a[47:32]});
  endtask

  task automatic drive_byte(input [7:0] b, input bit sof);
    @(negedge clk);
    da_vld = 1; da_sof = sof; da_byte = b;
  endtask

  task automatic idle();
    @(negedge clk);
    da_vld = 0; da_sof = 0; da_byte = 0;
  endtask

  task automatic expect_dec(input string tag, input bit acc, input int kind, input int slot);
    chk({tag, " valid"}, dec_valid, 1);
    chk({tag, " accept"}, dec_accept, acc);
    chk({tag, " kind"}, dec_kind, kind);
    chk({tag, " slot"}, dec_slot, slot);
  endtask

  task automatic send(input string tag, input [47:0] a, input bit acc, input int kind, input int slot);
    for (int n = 0; n < 6; n++) drive_byte(a[n * 8 +: 8], n == 0);
    idle();
    expect_dec(tag, acc, kind, slot);
    idle();
  endtask

  localparam logic [47:0] U1 = 48'h5544_3322_1100;
  localparam logic [47:0] U2 = 48'h0bad_cafe_0002;
  localparam logic [47:0] U3 = 48'h0000_0000_1234;
  localparam logic [47:0] M1 = 48'h0e00_00c2_8001;
  localparam logic [47:0] M2 = 48'h0101_0101_0103;
  localparam logic [47:0] BC = 48'hffff_ffff_ffff;

  logic [47:0] mlo, mhi;
  logic [5:0]  hlo, hhi;

  task automatic t_reset();
    chk("R11 dec_valid after reset", dec_valid, 0);
    chk("R11 dec_accept after reset", dec_accept, 0);
    send("R11 empty filter rejects unicast", U1, 0, K_NONE, 0);
    send("R11 empty filter rejects group", M1, 0, K_NONE, 0);
  endtask

  task automatic t_exact();
    cfg_wr(A_MODE, mode(0, 0, 0, 0, 4'd1));
    set_slot(0, U1);
    idle();
    send("R2 exact slot0", U1, 1, K_EXACT, 0);
    send("R2 unknown unicast", U2, 0, K_NONE, 0);
  endtask

  task automatic t_restart();
    drive_byte(8'haa, 1); drive_byte(8'hbb, 0); drive_byte(8'hcc, 0);
    idle();
    chk("R1 no decision on partial address", dec_valid, 0);
    for (int n = 0; n < 6; n++) drive_byte(U1[n * 8 +: 8], n == 0);
    idle();
    expect_dec("R1 restart decision", 1, K_EXACT, 0);
    idle();
    chk("R1 single-cycle pulse", dec_valid, 0);
    // a byte run with no start flag after a decision is not taken
    for (int n = 0; n < 6; n++) drive_byte(U1[n * 8 +: 8], 0);
    idle();
    chk("R1 bytes without start ignored", dec_valid, 0);
    idle();
  endtask

  task automatic t_arm();
    set_slot(2, M1);
    set_slot(5, M1);
    idle();
    send("R2 lowest index wins", M1, 1, K_EXACT, 2);
    cfg_wr(5'd4, M1[31:0]);
    idle();
    send("R3 low write disarms slot2", M1, 1, K_EXACT, 5);
    cfg_wr(5'd10, M1[31:0]);
    idle();
    send("R3 both disarmed", M1, 0, K_NONE, 0);
    cfg_wr(5'd11, {16'd0, M1[47:32]});
    idle();
    send("R3 high write rearms slot5", M1, 1, K_EXACT, 5);
    cfg_wr(5'd5, {16'd0, M1[47:32]});
    idle();
    send("R3 slot2 rearmed", M1, 1, K_EXACT, 2);
  endtask

  task automatic t_partition();
    set_slot(3, U3);
    idle();
    send("R4 unicast in multicast slot", U3, 0, K_NONE, 0);
    cfg_wr(A_MODE, mode(0, 0, 0, 0, 4'd4));
    idle();
    send("R4 unicast count 4 slot3", U3, 1, K_EXACT, 3);
    send("R4 group skips unicast slot2", M1, 1, K_EXACT, 5);
    set_slot(0, M2);
    cfg_wr(A_MODE, mode(0, 0, 0, 0, 4'd0));
    idle();
    send("R4 count 0 group in slot0", M2, 1, K_EXACT, 0);
    cfg_wr(A_MODE, mode(0, 0, 0, 0, 4'd1));
    idle();
    send("R4 count 1 group in slot0", M2, 0, K_NONE, 0);
    set_slot(0, U1);
    idle();
  endtask

  task automatic t_hash();
    bit got_lo = 0, got_hi = 0;
    for (int x = 0; x < 256; x++) begin
      logic [47:0] c = mk(8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'(x));
      if (!got_lo && fold(c) < 32) begin mlo = c; hlo = fold(c); got_lo = 1; end
      if (!got_hi && fold(c) >= 32) begin mhi = c; hhi = fold(c); got_hi = 1; end
    end
    cfg_wr(A_HLO, 32'd1 << hlo);
    cfg_wr(A_HHI, 32'd0);
    cfg_wr(A_MODE, mode(0, 0, 1, 0, 4'd1));
    idle();
    send("R5 hash low word hit", mlo, 1, K_HASH, 0);
    send("R5 hash high word bit clear", mhi, 0, K_NONE, 0);
    cfg_wr(A_HLO, 32'd0);
    cfg_wr(A_HHI, 32'd1 << (hhi - 6'd32));
    idle();
    send("R5 hash high word hit", mhi, 1, K_HASH, 0);
    send("R5 hash low word now clear", mlo, 0, K_NONE, 0);
    cfg_wr(A_MODE, mode(0, 0, 0, 0, 4'd1));
    idle();
    send("R5 hash disabled", mhi, 0, K_NONE, 0);
    cfg_wr(A_HLO, 32'hffff_ffff);
    cfg_wr(A_HHI, 32'hffff_ffff);
    cfg_wr(A_MODE, mode(0, 0, 1, 0, 4'd1));
    idle();
    send("R5 unicast ignores table", U2, 0, K_NONE, 0);
  endtask

  task automatic t_allmulti();
    cfg_wr(A_HLO, 32'd0);
    cfg_wr(A_HHI, 32'd0);
    cfg_wr(A_MODE, mode(0, 1, 0, 0, 4'd1));
    idle();
    send("R6 allmulti group", mhi, 1, K_HASH, 0);
    send("R6 allmulti unicast", U2, 0, K_NONE, 0);
  endtask

  task automatic t_priority();
    cfg_wr(A_HLO, 32'hffff_ffff);
    cfg_wr(A_HHI, 32'hffff_ffff);
    cfg_wr(A_MODE, mode(0, 0, 1, 0, 4'd1));
    idle();
    send("R7 exact before hash", M1, 1, K_EXACT, 2);
  endtask

  task automatic t_bcast();
    send("R8 broadcast accepted", BC, 1, K_BC, 0);
    cfg_wr(A_MODE, mode(0, 1, 1, 1, 4'd1));
    idle();
    send("R8 broadcast rejected", BC, 0, K_NONE, 0);
    cfg_wr(A_MODE, mode(1, 0, 0, 1, 4'd1));
    idle();
    send("R8 broadcast rejected but promisc", BC, 1, K_PROM, 0);
  endtask

  task automatic t_promisc();
    cfg_wr(A_MODE, mode(1, 0, 0, 0, 4'd1));
    idle();
    send("R9 promisc unknown unicast", U2, 1, K_PROM, 0);
    send("R9 promisc still reports exact", U1, 1, K_EXACT, 0);
  endtask

  task automatic t_midframe();
    cfg_wr(A_MODE, mode(0, 0, 0, 0, 4'd1));
    idle();
    drive_byte(U2[7:0], 1);
    drive_byte(U2[15:8], 0);
    drive_byte(U2[23:16], 0);
    @(negedge clk);
    da_vld = 0; da_sof = 0;
    cfg_we = 1; cfg_addr = A_MODE; cfg_wdata = mode(1, 0, 0, 0, 4'd1);
    @(negedge clk);
    cfg_we = 0;
    drive_byte(U2[31:24], 0);
    drive_byte(U2[39:32], 0);
    drive_byte(U2[47:40], 0);
    idle();
    expect_dec("R10 write during address not applied", 0, K_NONE, 0);
    idle();
    send("R10 write applied to next address", U2, 1, K_PROM, 0);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    da_vld = 0; da_sof = 0; da_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_restart();
    t_arm();
    t_partition();
    t_hash();
    t_allmulti();
    t_priority();
    t_bcast();
    t_promisc();
    t_midframe();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule